// File: doc/BRIEF.md
# Video Sync and Blank Level Inserter

This block sits at the end of a video output pipeline, just ahead of three digital-to-analog converters. Each clock it receives three 10-bit channel samples: channel 0 carries green or luma, and channels 1 and 2 carry blue/red or the two chroma components. It also receives three timing controls: an active-low sync strobe, an active-high tri-level strobe and an active-low blank strobe. For each channel it decides which level that channel drives in that cycle, and it registers a code together with a 2-bit level tag. A downstream converter stage can use the tag to add its own current contributions.

Sync has the highest priority. The tri-level excursion is next, and it only applies inside a sync period. Blanking comes after that, and active video is last. A mode input chooses whether sync goes onto channel 0 alone or onto all three channels. During sync, any channel that does not carry sync sits at its blanking level. A second mode input chooses the colour space, and that sets the chroma blanking code. Generating the sync timing and summing the analog currents are left to other blocks.

Top module: `vid_level_ins`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every tag reads blank (1) and every code reads 64.
- R2: The result for each cycle's inputs appears on the outputs one clock later. With `sync_n` low and `tri_hi` low, channel 0 gives tag 2 (sync tip) and code 0.
- R3: With `sync_n` low and `tri_hi` high, channel 0 gives tag 3 (tri-level high) and code 128.
- R4: With `sync_all` high during sync, channels 1 and 2 give the same tag and code as channel 0.
- R5: With `sync_all` low during sync, channels 1 and 2 give tag 1 and their blanking code.
- R6: While `sync_n` is low, `blank_n` has no effect on any output.
- R7: With `sync_n` high and `blank_n` low, every channel gives tag 1 and its blanking code, whatever its data input holds.
- R8: Blanking codes: channel 0 is always 64. Channels 1 and 2 are 512 when `ypbpr` is high and 64 when it is low.
- R9: With `sync_n` and `blank_n` both high, every channel gives tag 0 and a code equal to its own data input.
- R10: While `sync_n` is high, `tri_hi` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| din_y | input | 10 | Channel 0 sample (green or luma) |
| din_b | input | 10 | Channel 1 sample (blue or Pb) |
| din_r | input | 10 | Channel 2 sample (red or Pr) |
| sync_n | input | 1 | Sync period strobe, active low |
| tri_hi | input | 1 | Positive tri-level excursion strobe, active high |
| blank_n | input | 1 | Blank strobe, active low |
| sync_all | input | 1 | 1: sync on all channels, 0: sync on channel 0 only |
| ypbpr | input | 1 | 1: YPbPr blanking codes, 0: GBR blanking codes |
| code_y | output | 10 | Channel 0 output code |
| code_b | output | 10 | Channel 1 output code |
| code_r | output | 10 | Channel 2 output code |
| lvl_y | output | 2 | Channel 0 level tag |
| lvl_b | output | 2 | Channel 1 level tag |
| lvl_r | output | 2 | Channel 2 level tag |

## Verification
The bench drives blank low together with sync, in both sync-placement modes. A design that let blank outrank sync would lose the sync tip on channel 0 in that case. The bench also raises the tri-level strobe outside sync, during both active video and blanking. A design that decoded that strobe without checking sync would insert spurious positive pulses. Chroma channels are checked during sync with `sync_all` low in YPbPr mode, where they must sit at 512 rather than 64 or a sync level; this catches a wrong blanking-code choice or a sync mode applied to the wrong channels. Random control and data streams, including a reset in the middle of the run, are compared cycle by cycle against a behavioural model to catch latency errors.

// File: rtl/vlm_pkg.sv
package vlm_pkg;
  typedef enum logic [1:0] {
    LVL_ACTIVE = 2'd0,
    LVL_BLANK  = 2'd1,
    LVL_TIP    = 2'd2,
    LVL_HIGH   = 2'd3
  } lvl_e;
endpackage

// File: rtl/vlm_level_sel.sv
// Per-channel priority decode: sync > tri-level > blank > active.
module vlm_level_sel
  import vlm_pkg::*;
(
  input  logic sync_n,
  input  logic tri_hi,
  input  logic blank_n,
  input  logic carries_sync,
  output lvl_e lvl
);
  always_comb begin
    if (!sync_n) begin
      if (carries_sync) lvl = tri_hi ? LVL_HIGH : LVL_TIP;
      else              lvl = LVL_BLANK;
    end else if (!blank_n) begin
      lvl = LVL_BLANK;
    end else begin
      lvl = LVL_ACTIVE;
    end
  end
endmodule

// File: rtl/vlm_chan_reg.sv
// Output register for one channel: maps a level to a code and holds it.
module vlm_chan_reg
  import vlm_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int TIP_CODE   = 0,
  parameter int HIGH_CODE  = 128,
  parameter int RESET_CODE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  lvl_e              lvl_in,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] blank_code,
  output logic [DATA_W-1:0] code_q,
  output lvl_e              lvl_q
);
  localparam logic [DATA_W-1:0] TIP_C   = DATA_W'(TIP_CODE);
  localparam logic [DATA_W-1:0] HIGH_C  = DATA_W'(HIGH_CODE);
  localparam logic [DATA_W-1:0] RESET_C = DATA_W'(RESET_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= RESET_C;
      lvl_q  <= LVL_BLANK;
    end else begin
      lvl_q <= lvl_in;
      unique case (lvl_in)
        LVL_ACTIVE: code_q <= din;
        LVL_BLANK:  code_q <= blank_code;
        LVL_TIP:    code_q <= TIP_C;
        default:    code_q <= HIGH_C;
      endcase
    end
  end
endmodule

// File: rtl/vid_level_ins.sv
module vid_level_ins
  import vlm_pkg::*;
#(
  parameter int DATA_W       = 10,
  parameter int LUMA_BLANK   = 64,
  parameter int CHROMA_BLANK = 512,
  parameter int SYNC_TIP     = 0,
  parameter int SYNC_HIGH    = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din_y,
  input  logic [DATA_W-1:0] din_b,
  input  logic [DATA_W-1:0] din_r,
  input  logic              sync_n,
  input  logic              tri_hi,
  input  logic              blank_n,
  input  logic              sync_all,
  input  logic              ypbpr,
  output logic [DATA_W-1:0] code_y,
  output logic [DATA_W-1:0] code_b,
  output logic [DATA_W-1:0] code_r,
  output logic [1:0]        lvl_y,
  output logic [1:0]        lvl_b,
  output logic [1:0]        lvl_r
);
  localparam int NCH = 3;
  localparam logic [DATA_W-1:0] LUMA_C   = DATA_W'(LUMA_BLANK);
  localparam logic [DATA_W-1:0] CHROMA_C = DATA_W'(CHROMA_BLANK);

  logic [DATA_W-1:0] din_a  [NCH];
  logic [DATA_W-1:0] code_a [NCH];
  lvl_e              lvl_a  [NCH];

  assign din_a[0] = din_y;
  assign din_a[1] = din_b;
  assign din_a[2] = din_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic              carries;
    logic [DATA_W-1:0] blank_c;
    lvl_e              lvl_d;

    if (ch == 0) begin : g_luma
      assign carries = 1'b1;
      assign blank_c = LUMA_C;
    end else begin : g_chroma
      assign carries = sync_all;
      assign blank_c = ypbpr ? CHROMA_C : LUMA_C;
    end

    vlm_level_sel u_sel (
      .sync_n       (sync_n),
      .tri_hi       (tri_hi),
      .blank_n      (blank_n),
      .carries_sync (carries),
      .lvl          (lvl_d)
    );

    vlm_chan_reg #(
      .DATA_W     (DATA_W),
      .TIP_CODE   (SYNC_TIP),
      .HIGH_CODE  (SYNC_HIGH),
      .RESET_CODE (LUMA_BLANK)
    ) u_reg (
      .clk        (clk),
      .rst        (rst),
      .lvl_in     (lvl_d),
      .din        (din_a[ch]),
      .blank_code (blank_c),
      .code_q     (code_a[ch]),
      .lvl_q      (lvl_a[ch])
    );
  end

  assign code_y = code_a[0];
  assign code_b = code_a[1];
  assign code_r = code_a[2];
  assign lvl_y  = lvl_a[0];
  assign lvl_b  = lvl_a[1];
  assign lvl_r  = lvl_a[2];
endmodule

// File: rtl/vid_level_ins_chk.sv
module vid_level_ins_chk #(
  parameter int DATA_W       = 10,
  parameter int LUMA_BLANK   = 64,
  parameter int CHROMA_BLANK = 512,
  parameter int SYNC_TIP     = 0,
  parameter int SYNC_HIGH    = 128
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] din_y,
  input logic              sync_n,
  input logic              tri_hi,
  input logic              blank_n,
  input logic              sync_all,
  input logic [DATA_W-1:0] code_y,
  input logic [DATA_W-1:0] code_b,
  input logic [DATA_W-1:0] code_r,
  input logic [1:0]        lvl_y,
  input logic [1:0]        lvl_b,
  input logic [1:0]        lvl_r
);
  // R2
  sync_tip_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && !tri_hi) |=> (lvl_y == 2'd2 && code_y == DATA_W'(SYNC_TIP)));

  // R3
  tri_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && tri_hi) |=> (lvl_y == 2'd3 && code_y == DATA_W'(SYNC_HIGH)));

  // R4
  sync_all_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && sync_all) |=> (lvl_b == lvl_y && lvl_r == lvl_y &&
                               code_b == code_y && code_r == code_y));

  // R5
  sync_luma_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && !sync_all) |=> (lvl_b == 2'd1 && lvl_r == 2'd1));

  // R7
  blank_all_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_n && !blank_n) |=> (lvl_y == 2'd1 && lvl_b == 2'd1 && lvl_r == 2'd1 &&
                              code_y == DATA_W'(LUMA_BLANK)));

  // R9
  active_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_n && blank_n) |=> (lvl_y == 2'd0 && code_y == $past(din_y)));
endmodule

bind vid_level_ins vid_level_ins_chk #(
  .DATA_W       (DATA_W),
  .LUMA_BLANK   (LUMA_BLANK),
  .CHROMA_BLANK (CHROMA_BLANK),
  .SYNC_TIP     (SYNC_TIP),
  .SYNC_HIGH    (SYNC_HIGH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .din_y    (din_y),
  .sync_n   (sync_n),
  .tri_hi   (tri_hi),
  .blank_n  (blank_n),
  .sync_all (sync_all),
  .code_y   (code_y),
  .code_b   (code_b),
  .code_r   (code_r),
  .lvl_y    (lvl_y),
  .lvl_b    (lvl_b),
  .lvl_r    (lvl_r)
);

// File: tb/vid_level_ins_bench.sv
module vid_level_ins_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst;
  logic [9:0] din_y, din_b, din_r;
  logic       sync_n, tri_hi, blank_n, sync_all, ypbpr;
  logic [9:0] code_y, code_b, code_r;
  logic [1:0] lvl_y, lvl_b, lvl_r;

  vid_level_ins u_vid_level_ins (
    .clk(clk), .rst(rst), .din_y(din_y), .din_b(din_b), .din_r(din_r),
    .sync_n(sync_n), .tri_hi(tri_hi), .blank_n(blank_n),
    .sync_all(sync_all), .ypbpr(ypbpr),
    .code_y(code_y), .code_b(code_b), .code_r(code_r),
    .lvl_y(lvl_y), .lvl_b(lvl_b), .lvl_r(lvl_r)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit    have_exp = 0;
  int    exp_code [3];
  int    exp_lvl  [3];
  string exp_req  [3];

  task automatic check_one(input int ch, input int gc, input int gl);
    checks++;
    if (gc != exp_code[ch] || gl != exp_lvl[ch]) begin
      errors++;
      $display("FAIL %s ch%0d: code=%0d lvl=%0d expected code=%0d lvl=%0d",
               exp_req[ch], ch, gc, gl, exp_code[ch], exp_lvl[ch]);
    end
  endtask

  // Behavioural model of the requirements for the inputs just applied.
  task automatic predict();
    int d [3];
    d[0] = din_y; d[1] = din_b; d[2] = din_r;
    for (int ch = 0; ch < 3; ch++) begin
      int bl;
      bl = (ch != 0 && ypbpr) ? 512 : 64;                 // R8
      if (rst) begin
        exp_lvl[ch] = 1; exp_code[ch] = 64; exp_req[ch] = "R1";
      end else if (!sync_n) begin
        if (ch == 0 || sync_all) begin
          exp_lvl[ch]  = tri_hi ? 3 : 2;
          exp_code[ch] = tri_hi ? 128 : 0;
          exp_req[ch]  = (ch != 0) ? "R4" : (!blank_n ? "R6" : (tri_hi ? "R3" : "R2"));
        end else begin
          exp_lvl[ch] = 1; exp_code[ch] = bl;
          exp_req[ch] = !blank_n ? "R6" : (ypbpr ? "R8" : "R5");
        end
      end else if (!blank_n) begin
        exp_lvl[ch] = 1; exp_code[ch] = bl;
        exp_req[ch] = tri_hi ? "R10" : ((ypbpr && ch != 0) ? "R8" : "R7");
      end else begin
        exp_lvl[ch] = 0; exp_code[ch] = d[ch];
        exp_req[ch] = tri_hi ? "R10" : "R9";
      end
    end
  endtask

  task automatic step(input logic r, input logic sn, input logic th, input logic bn,
                      input logic sa, input logic ym,
                      input logic [9:0] y, input logic [9:0] b, input logic [9:0] rr);
    @(negedge clk);
    if (have_exp) begin
      check_one(0, code_y, lvl_y);
      check_one(1, code_b, lvl_b);
      check_one(2, code_r, lvl_r);
    end
    rst = r; sync_n = sn; tri_hi = th; blank_n = bn; sync_all = sa; ypbpr = ym;
    din_y = y; din_b = b; din_r = rr;
    predict();
    have_exp = 1;
  endtask

  initial begin
    rst = 1; sync_n = 1; tri_hi = 0; blank_n = 1; sync_all = 0; ypbpr = 0;
    din_y = 0; din_b = 0; din_r = 0;
    // R1: reset state held, then checked
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, 0, 10'd900, 10'd901, 10'd902);
    // R9: active video, several patterns
    step(0, 1, 0, 1, 0, 0, 10'd1023, 10'd0, 10'd345);
    step(0, 1, 0, 1, 1, 1, 10'd5, 10'd777, 10'd512);
    // R7 / R8: blanking in GBR, then YPbPr
    step(0, 1, 0, 0, 0, 0, 10'd700, 10'd701, 10'd702);
    step(0, 1, 0, 0, 0, 1, 10'd700, 10'd701, 10'd702);
    // R2 / R5: bi-level sync on channel 0 only, YPbPr
    step(0, 0, 0, 1, 0, 1, 10'd300, 10'd301, 10'd302);
    // R3: tri-level high, channel 0 only, GBR
    step(0, 0, 1, 1, 0, 0, 10'd300, 10'd301, 10'd302);
    // R4: sync on all channels, tip then high
    step(0, 0, 0, 1, 1, 1, 10'd11, 10'd12, 10'd13);
    step(0, 0, 1, 1, 1, 1, 10'd11, 10'd12, 10'd13);
    // R6: blank low during sync in both placement modes
    step(0, 0, 0, 0, 0, 1, 10'd40, 10'd41, 10'd42);
    step(0, 0, 1, 0, 1, 0, 10'd40, 10'd41, 10'd42);
    // R10: tri-level strobe outside sync, active then blank
    step(0, 1, 1, 1, 1, 0, 10'd600, 10'd601, 10'd602);
    step(0, 1, 1, 0, 1, 1, 10'd600, 10'd601, 10'd602);
    // Random run with a mid-run reset (R1)
    for (int i = 0; i < 400; i++) begin
      step(i == 200 || i == 201, 1'($urandom_range(0, 2) != 0), 1'($urandom),
           1'($urandom_range(0, 2) != 0), 1'($urandom), 1'($urandom),
           10'($urandom), 10'($urandom), 10'($urandom));
    end
    step(0, 1, 0, 1, 0, 0, 10'd0, 10'd0, 10'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule